// File: doc/BRIEF.md
# Debounced Level Interrupt Bank

This block watches eight asynchronous external inputs and turns each into a clean, level-sensitive interrupt request. Every input is first brought into the clock domain by a two-stage synchroniser. A per-channel filter then passes a new level through only after the input has held it for a programmed number of milliseconds. The millisecond time base comes from a prescaler that divides the system clock by `CLK_HZ/1000`.

Each channel has a one-shot arm bit. The channel records a pending status when three things are true: the channel is enabled, its arm bit is set, and its filtered level matches its polarity bit. Recording the status clears the arm bit in the same cycle, so software must re-arm the channel before it can fire again. Software emulates edge behaviour by flipping the polarity and re-arming.

All control and status is reached through a flat 32-bit register port. A single output, the OR of the enabled pending bits, signals the interrupt.

Top module: `eic_dbnc_bank`

## Requirements
- R1: After reset every register reads 0, the filtered levels are 0 and `irq` is low.
- R2: The channel enable (0x04), polarity (0x14), interrupt enable (0x18) and arm (0x28) registers read back the low 8 bits last written, with bits [31:8] reading 0. Each filter control register at 0x40 + 4·channel keeps all 32 bits written.
- R3: Reading 0x00 returns the filtered level of each enabled channel and 0 for each disabled channel, one bit per channel with bit n for channel n.
- R4: The filtered level of a channel takes a new input level only after that level has been held for N millisecond ticks, where N is bits [11:0] of its filter control register and a value of 0 acts as 1. One tick lasts `CLK_HZ/1000` clock cycles. An input held for at most N−1 ms is ignored, and one held for N+1 ms is always taken.
- R5: A channel's raw status bit (0x1C) is set when the channel is enabled, its arm bit is 1, and its filtered level equals its polarity bit. Polarity 1 selects high and polarity 0 selects low.
- R6: In the cycle a status bit is set, that channel's arm bit clears. No new status is recorded for the channel until 1 is written to its arm bit again.
- R7: Writing to 0x24 clears each raw status bit whose data bit is 1 and leaves bits written 0 unchanged. A status set in the same cycle as a clear wins.
- R8: The masked status (0x20) equals raw status AND interrupt enable, and `irq` is high exactly when any masked status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 8 | Asynchronous external inputs, bit n is channel n |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of a read access |
| irq | output | 1 | Combined interrupt request |

## Verification
The filter is tested by raising all eight inputs together while the eight channels hold different filter lengths, including a field of 0. The bench samples the data register at every millisecond boundary, so each channel must stay low before its length and be high after it. A pulse shorter than the filter length, followed by a long one, separates glitch rejection from a real level change. Interrupt patterns cover high and low polarity against a steady level, a disabled channel, a disarmed channel, and partial clears. Together these show that the one-shot arm, the clear mask and the interrupt-enable mask act on the right bits.

// File: rtl/eic_dbnc_bank.sv
module eic_dbnc_bank #(
  parameter int CLK_HZ = 125_000_000,
  parameter int NCH    = 8,
  parameter int DW     = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  ext_in,
  input  logic            reg_valid,
  input  logic            reg_write,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq
);
  localparam int TICK_DIV = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int PW = $clog2(TICK_DIV) + 1;
  localparam int CW = (NCH < 2) ? 1 : $clog2(NCH);
  localparam logic [7:0] CTRL_BASE = 8'h40;

  logic [NCH-1:0] sync1, sync2, db, en, pol, ie, raw, arm, hit;
  logic [31:0]    dbc [NCH];
  logic [DW-1:0]  cnt [NCH];
  logic [PW-1:0]  pre;
  logic           tick;

  wire wr      = reg_valid & reg_write;
  wire wr_en   = wr && reg_addr == 8'h04;
  wire wr_pol  = wr && reg_addr == 8'h14;
  wire wr_ie   = wr && reg_addr == 8'h18;
  wire wr_clr  = wr && reg_addr == 8'h24;
  wire arm_wr  = wr && reg_addr == 8'h28;
  wire ctrl_sel = reg_addr[1:0] == 2'b00 &&
                  reg_addr >= CTRL_BASE && reg_addr < CTRL_BASE + 8'(4 * NCH);
  wire [CW-1:0] ctrl_idx = reg_addr[CW+1:2];

  assign tick = pre == PW'(TICK_DIV - 1);
  assign hit  = en & arm & ~(db ^ pol);
  assign irq  = |(raw & ie);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= tick ? '0 : pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= ext_in;
      sync2 <= sync1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      db <= '0;
      for (int i = 0; i < NCH; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (sync2[i] == db[i]) cnt[i] <= '0;
        else if (tick) begin
          if ((DW+1)'(cnt[i]) + 1'b1 >= (DW+1)'((dbc[i][DW-1:0] == '0) ? DW'(1) : dbc[i][DW-1:0])) begin
            db[i]  <= sync2[i];
            cnt[i] <= '0;
          end else cnt[i] <= cnt[i] + 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en  <= '0;
      pol <= '0;
      ie  <= '0;
      raw <= '0;
      arm <= '0;
      for (int i = 0; i < NCH; i++) dbc[i] <= '0;
    end else begin
      if (wr_en)  en  <= reg_wdata[NCH-1:0];
      if (wr_pol) pol <= reg_wdata[NCH-1:0];
      if (wr_ie)  ie  <= reg_wdata[NCH-1:0];
      raw <= (raw & ~(wr_clr ? reg_wdata[NCH-1:0] : '0)) | hit;
      arm <= arm_wr ? reg_wdata[NCH-1:0] : (arm & ~hit);
      if (wr && ctrl_sel) dbc[ctrl_idx] <= reg_wdata;
    end

  always_comb begin
    reg_rdata = '0;
    if (reg_valid && !reg_write) begin
      case (reg_addr)
        8'h00: reg_rdata = 32'(db & en);
        8'h04: reg_rdata = 32'(en);
        8'h14: reg_rdata = 32'(pol);
        8'h18: reg_rdata = 32'(ie);
        8'h1C: reg_rdata = 32'(raw);
        8'h20: reg_rdata = 32'(raw & ie);
        8'h28: reg_rdata = 32'(arm);
        default: if (ctrl_sel) reg_rdata = dbc[ctrl_idx];
      endcase
    end
  end
endmodule

// File: rtl/eic_dbnc_bank_chk.sv
module eic_dbnc_bank_chk #(parameter int NCH = 8) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic [NCH-1:0] sync2,
  input logic [NCH-1:0] db,
  input logic [NCH-1:0] en,
  input logic [NCH-1:0] pol,
  input logic [NCH-1:0] ie,
  input logic [NCH-1:0] raw,
  input logic [NCH-1:0] arm,
  input logic           arm_wr,
  input logic           irq
);
  assert_db_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(db));

  assert_db_follows_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((db ^ $past(db)) & ~($past(sync2) ^ $past(db))) == '0);

  assert_set_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & ~$past(raw)) & ~$past(arm)) == '0);

  assert_set_needs_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & ~$past(raw)) & ~$past(en & ~(db ^ pol))) == '0);

  assert_arm_self_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(arm_wr) |-> ((raw & ~$past(raw)) & arm) == '0);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == '0) |-> !irq);
endmodule

bind eic_dbnc_bank eic_dbnc_bank_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sync2(sync2), .db(db), .en(en),
  .pol(pol), .ie(ie), .raw(raw), .arm(arm), .arm_wr(arm_wr), .irq(irq)
);

// File: tb/eic_dbnc_bank_tb_top.sv
`timescale 1ns/1ps
module eic_dbnc_bank_tb_top;
  localparam int P = 8;
  logic clk = 0, rst_n = 0;
  logic [7:0] ext_in = '0;
  logic reg_valid = 0, reg_write = 0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  eic_dbnc_bank #(.CLK_HZ(P * 1000)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp,
                    input logic [31:0] care, input string req);
    logic [31:0] got;
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    #1 got = reg_rdata;
    reg_valid = 0;
    tests++;
    if (((got ^ exp) & care) != 0) begin
      fails++;
      $display("FAIL %s addr=%02h got=%08h exp=%08h care=%08h", req, a, got, exp, care);
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    @(negedge clk);
    tests++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq got=%0b exp=%0b", req, irq, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] pats [4] = '{8'hA5, 8'h5A, 8'hFF, 8'h00};
    logic [7:0] rw_addr [4] = '{8'h04, 8'h14, 8'h18, 8'h28};
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset state
    for (int a = 0; a < 12; a++) rd(8'(a * 4), 0, '1, "R1");
    for (int c = 0; c < 8; c++) rd(8'h40 + 8'(4 * c), 0, '1, "R1");
    chk_irq(0, "R1");

    // R2 read/write sweep
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 4; p++) begin
        wr(rw_addr[r], {24'hFFFFFF, pats[p]});
        rd(rw_addr[r], {24'h0, pats[p]}, '1, "R2");
      end
    for (int c = 0; c < 8; c++) begin
      wr(8'h40 + 8'(4 * c), 32'hDEAD0000 | 32'(c * 32'h111));
      rd(8'h40 + 8'(4 * c), 32'hDEAD0000 | 32'(c * 32'h111), '1, "R2");
    end
    wr(8'h24, 32'hFF);

    // R4 filter sweep: channel c uses max(c,1) ms, channel 0 field 0
    for (int c = 0; c < 8; c++) wr(8'h40 + 8'(4 * c), 32'hABC00000 | 32'(c));
    wr(8'h04, 32'hFF);
    idle(4 * P);
    @(negedge clk);
    ext_in = 8'hFF;
    for (int k = 1; k <= 10; k++) begin
      logic [7:0] e, m;
      e = '0; m = '0;
      for (int c = 0; c < 8; c++) begin
        int n;
        n = (c == 0) ? 1 : c;
        if (n <= k - 1) begin e[c] = 1; m[c] = 1; end
        else if (n >= k + 1) m[c] = 1;
      end
      idle(P - 1);
      rd(8'h00, 32'(e), 32'(m), "R4");
    end
    // R3 enable gating of the data view
    wr(8'h04, 32'h3C);
    rd(8'h00, 32'h3C, '1, "R3");
    wr(8'h04, 32'hFF);
    rd(8'h00, 32'hFF, '1, "R3");

    // R4 glitch rejection and real change with N = 4
    for (int c = 0; c < 8; c++) wr(8'h40 + 8'(4 * c), 32'h4);
    @(negedge clk); ext_in = 8'h00;
    idle(2 * P);
    ext_in = 8'hFF;
    idle(6 * P);
    rd(8'h00, 32'hFF, '1, "R4");
    ext_in = 8'h00;
    idle(6 * P);
    rd(8'h00, 32'h00, '1, "R4");
    ext_in = 8'hFF;
    idle(6 * P);
    rd(8'h00, 32'hFF, '1, "R4");
    for (int c = 0; c < 8; c++) wr(8'h40 + 8'(4 * c), 32'h1);

    // R5/R6/R8 high polarity, all armed
    wr(8'h14, 32'hFF);
    wr(8'h18, 32'hFF);
    wr(8'h28, 32'hFF);
    idle(3);
    rd(8'h1C, 32'hFF, '1, "R5");
    rd(8'h28, 32'h00, '1, "R6");
    rd(8'h20, 32'hFF, '1, "R8");
    chk_irq(1, "R8");
    wr(8'h24, 32'hFF);
    idle(2);
    rd(8'h1C, 32'h00, '1, "R7");
    chk_irq(0, "R8");
    idle(20);
    rd(8'h1C, 32'h00, '1, "R6");
    wr(8'h28, 32'h08);
    idle(3);
    rd(8'h1C, 32'h08, '1, "R6");
    wr(8'h18, 32'h00);
    idle(2);
    rd(8'h20, 32'h00, '1, "R8");
    chk_irq(0, "R8");
    rd(8'h1C, 32'h08, '1, "R8");
    wr(8'h24, 32'hF7);
    idle(2);
    rd(8'h1C, 32'h08, '1, "R7");
    wr(8'h24, 32'h08);
    idle(2);
    rd(8'h1C, 32'h00, '1, "R7");

    // R5 low polarity
    wr(8'h14, 32'h00);
    wr(8'h18, 32'hFF);
    wr(8'h28, 32'hFF);
    idle(3);
    rd(8'h1C, 32'h00, '1, "R5");
    rd(8'h28, 32'hFF, '1, "R6");
    ext_in = 8'hF0;
    idle(4 * P);
    rd(8'h1C, 32'h0F, '1, "R5");
    rd(8'h28, 32'hF0, '1, "R6");
    chk_irq(1, "R8");
    wr(8'h24, 32'hFF);

    // R5 enable gating
    wr(8'h04, 32'h0F);
    wr(8'h14, 32'hFF);
    idle(3);
    rd(8'h1C, 32'h00, '1, "R5");
    rd(8'h00, 32'h00, '1, "R3");
    wr(8'h04, 32'hFF);
    idle(3);
    rd(8'h1C, 32'hF0, '1, "R5");
    rd(8'h28, 32'h00, '1, "R6");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule